// File: doc/BRIEF.md
# ECC Event Monitor with Masked Global Interrupt

This block sits beside a group of memory error-correction wrappers, one wrapper per on-chip SRAM. Each wrapper reports two kinds of diagnostic event: a corrected single-bit error and a detected, uncorrectable double-bit error. Each event comes with the address and data word of the failing access. The monitor keeps per-unit sticky flags and a capture of the first failing access. It merges every pending, unmasked flag into one registered interrupt line.

Software reaches the monitor over a 32-bit register port with a valid/ready request, a byte address, write data, byte strobes and registered read data. A unit is switched off together with its memory. While it is off, its events are dropped. Interrupt contributions can be enabled per unit and per event kind, and a global enable gates the whole line.

Top module: `ecc_event_hub`

## Requirements
- R1: After reset the global enable, every unit control register, every flag and every capture register read as zero, all units are disabled, and `irq` is low.
- R2: `reg_ready` is always high. A read accepted on a clock edge returns its value on `reg_rdata` with `reg_rvalid` high during the following cycle. Address bits [1:0] are ignored. Offset 0x00 holds the global interrupt enable in bit 0. Unit u occupies 0x20+16*u: +0x0 control (bit 0 unit enable, bit 1 single-error interrupt enable, bit 2 double-error interrupt enable), +0x4 status (bit 0 single-error flag, bit 1 double-error flag), +0x8 captured address, +0xC captured data. Every other address reads as zero.
- R3: A write changes a register only when `reg_wstrb[0]` is set. Writes to the captured-address and captured-data registers have no effect.
- R4: A single-error or double-error event from an enabled unit sets that unit's matching flag on the clock edge where the event is sampled. Other units are not affected.
- R5: Events from a unit whose enable bit is 0 set no flag and capture nothing.
- R6: Writing 1 to a status bit clears that flag. Writing 0 leaves it unchanged.
- R7: When an event and a clear of the same flag fall on the same edge, the flag ends up set.
- R8: A unit captures the address and data of its first error. The capture stays frozen while either of its flags remains set.
- R9: An event captures when the unit's flags, after any clear applied on the same edge, are both zero.
- R10: `irq` is the OR over all units of flags ANDed with their interrupt enables, gated by the global enable, and registered once. It follows a flag or control change one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register request valid |
| reg_ready | output | 1 | Register request accepted (always high) |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | REG_AW | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_wstrb | input | 4 | Byte write strobes |
| reg_rdata | output | 32 | Read data |
| reg_rvalid | output | 1 | Read data valid |
| ev_sec | input | N_UNITS | Per-unit corrected single-error event |
| ev_ded | input | N_UNITS | Per-unit detected double-error event |
| ev_addr | input | N_UNITS*AW | Per-unit failing address, unit u at [u*AW +: AW] |
| ev_data | input | N_UNITS*DW | Per-unit failing data, unit u at [u*DW +: DW] |
| irq | output | 1 | Global interrupt |

## Verification
A flag is set on the edge that samples its event, so a read issued in the next cycle already sees it. That read's data arrives with `reg_rvalid` one further cycle on. `irq` trails any flag, enable or global-enable change by exactly one cycle. The bench checks that it is still low right after an event and high one cycle later. Expected read values go into a queue when the read is issued. They are compared only in the cycle where `reg_rvalid` is high, and all sampling is done on the falling clock edge.

// File: rtl/ecc_hub_pkg.sv
package ecc_hub_pkg;

  localparam logic [15:0] UNIT_BASE    = 16'h0020;
  localparam int unsigned UNIT_SPAN_LG = 4;

  typedef enum logic [1:0] {
    WD_CTRL  = 2'd0,
    WD_STAT  = 2'd1,
    WD_FADDR = 2'd2,
    WD_FDATA = 2'd3
  } unit_word_e;

  typedef struct packed {
    logic ded_ie;
    logic sec_ie;
    logic en;
  } unit_ctrl_t;

  // Index of the unit window an address falls in (only meaningful above UNIT_BASE)
  function automatic logic [15:0] unit_index(input logic [15:0] a);
    return (a - UNIT_BASE) >> UNIT_SPAN_LG;
  endfunction

  function automatic unit_word_e word_sel(input logic [15:0] a);
    return unit_word_e'(a[3:2]);
  endfunction

  // Flags left after a write-one-to-clear
  function automatic logic [1:0] after_clear(input logic [1:0] flags, input logic [1:0] clr);
    return flags & ~clr;
  endfunction

  // Interrupt contribution of one unit
  function automatic logic [1:0] unit_pending(input logic [1:0] flags, input unit_ctrl_t c);
    return flags & {c.ded_ie, c.sec_ie};
  endfunction

endpackage

// File: rtl/ecc_unit_slot.sv
module ecc_unit_slot
  import ecc_hub_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  unit_ctrl_t    ctrl_wr,
  input  logic          clr_sec,
  input  logic          clr_ded,
  input  logic          ev_sec,
  input  logic          ev_ded,
  input  logic [AW-1:0] ev_addr,
  input  logic [DW-1:0] ev_data,
  output unit_ctrl_t    ctrl_q,
  output logic [1:0]    flags_q,
  output logic [AW-1:0] cap_addr_q,
  output logic [DW-1:0] cap_data_q,
  output logic [1:0]    pend,
  output logic          cap_fire
);

  logic       sec_hit;
  logic       ded_hit;
  logic [1:0] flags_kept;
  logic [1:0] flags_d;

  assign sec_hit    = ev_sec & ctrl_q.en;
  assign ded_hit    = ev_ded & ctrl_q.en;
  assign flags_kept = after_clear(flags_q, {clr_ded, clr_sec});
  assign flags_d    = flags_kept | {ded_hit, sec_hit};
  assign cap_fire   = (sec_hit | ded_hit) & (flags_kept == 2'b00);
  assign pend       = unit_pending(flags_q, ctrl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= 2'b00;
    end else begin
      flags_q <= flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr_q <= '0;
      cap_data_q <= '0;
    end else if (cap_fire) begin
      cap_addr_q <= ev_addr;
      cap_data_q <= ev_data;
    end
  end

endmodule

// File: rtl/ecc_irq_merge.sv
module ecc_irq_merge #(
  parameter int unsigned N_UNITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 gie,
  input  logic [2*N_UNITS-1:0] pend,
  output logic                 irq_q
);

  function automatic logic any_set(input logic [2*N_UNITS-1:0] v);
    logic r;
    r = 1'b0;
    for (int i = 0; i < 2 * N_UNITS; i++) begin
      r = r | v[i];
    end
    return r;
  endfunction

  logic irq_d;
  assign irq_d = gie & any_set(pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/ecc_reg_port.sv
module ecc_reg_port
  import ecc_hub_pkg::*;
#(
  parameter int unsigned N_UNITS = 4,
  parameter int unsigned REG_AW  = 12,
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_valid,
  input  logic                  reg_write,
  input  logic [REG_AW-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  input  logic [3:0]            reg_wstrb,
  input  logic [3*N_UNITS-1:0]  ctrl_flat,
  input  logic [2*N_UNITS-1:0]  flag_flat,
  input  logic [N_UNITS*AW-1:0] cap_addr_flat,
  input  logic [N_UNITS*DW-1:0] cap_data_flat,
  output logic                  gie_q,
  output unit_ctrl_t            ctrl_wr,
  output logic [N_UNITS-1:0]    ctrl_we,
  output logic [N_UNITS-1:0]    clr_sec,
  output logic [N_UNITS-1:0]    clr_ded,
  output logic [31:0]           reg_rdata,
  output logic                  reg_rvalid
);

  logic [15:0] a16;
  logic        wr_go;
  logic        rd_go;
  logic        gie_we;
  logic        in_units;
  logic [15:0] idx;
  unit_word_e  word;
  logic [31:0] rd_val;
  logic        unused_bits;

  assign a16         = 16'(reg_addr);
  assign wr_go       = reg_valid & reg_write & reg_wstrb[0];
  assign rd_go       = reg_valid & ~reg_write;
  assign in_units    = (a16 >= UNIT_BASE) && (unit_index(a16) < 16'(N_UNITS));
  assign idx         = unit_index(a16);
  assign word        = word_sel(a16);
  assign gie_we      = wr_go && (a16[15:2] == 14'd0);
  assign ctrl_wr     = unit_ctrl_t'(reg_wdata[2:0]);
  assign unused_bits = ^{reg_wdata[31:3], reg_wstrb[3:1], a16[1:0]};

  for (genvar u = 0; u < N_UNITS; u++) begin : g_dec
    logic hit;
    assign hit        = wr_go && in_units && (idx == 16'(u));
    assign ctrl_we[u] = hit && (word == WD_CTRL);
    assign clr_sec[u] = hit && (word == WD_STAT) && reg_wdata[0];
    assign clr_ded[u] = hit && (word == WD_STAT) && reg_wdata[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
    end else if (gie_we) begin
      gie_q <= reg_wdata[0];
    end
  end

  always_comb begin
    rd_val = '0;
    if (a16[15:2] == 14'd0) begin
      rd_val[0] = gie_q;
    end else if (in_units) begin
      for (int u = 0; u < N_UNITS; u++) begin
        if (idx == 16'(u)) begin
          case (word)
            WD_CTRL:  rd_val = 32'(ctrl_flat[3*u +: 3]);
            WD_STAT:  rd_val = 32'(flag_flat[2*u +: 2]);
            WD_FADDR: rd_val = 32'(cap_addr_flat[u*AW +: AW]);
            default:  rd_val = 32'(cap_data_flat[u*DW +: DW]);
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= rd_go;
      if (rd_go) begin
        reg_rdata <= rd_val;
      end
    end
  end

endmodule

// File: rtl/ecc_event_hub.sv
module ecc_event_hub
  import ecc_hub_pkg::*;
#(
  parameter int unsigned N_UNITS = 4,
  parameter int unsigned REG_AW  = 12,
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_valid,
  output logic                  reg_ready,
  input  logic                  reg_write,
  input  logic [REG_AW-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  input  logic [3:0]            reg_wstrb,
  output logic [31:0]           reg_rdata,
  output logic                  reg_rvalid,
  input  logic [N_UNITS-1:0]    ev_sec,
  input  logic [N_UNITS-1:0]    ev_ded,
  input  logic [N_UNITS*AW-1:0] ev_addr,
  input  logic [N_UNITS*DW-1:0] ev_data,
  output logic                  irq
);

  localparam int unsigned FLAG_W = 2 * N_UNITS;
  localparam int unsigned CTRL_W = 3 * N_UNITS;

  logic                  gie_q;
  unit_ctrl_t            ctrl_wr;
  logic [N_UNITS-1:0]    ctrl_we;
  logic [N_UNITS-1:0]    clr_sec;
  logic [N_UNITS-1:0]    clr_ded;
  logic [CTRL_W-1:0]     ctrl_flat;
  logic [FLAG_W-1:0]     flag_flat;
  logic [FLAG_W-1:0]     clr_flat;
  logic [FLAG_W-1:0]     pend_flat;
  logic [N_UNITS-1:0]    cap_fire_vec;
  logic [N_UNITS*AW-1:0] cap_addr_flat;
  logic [N_UNITS*DW-1:0] cap_data_flat;

  assign reg_ready = 1'b1;

  ecc_reg_port #(
    .N_UNITS(N_UNITS), .REG_AW(REG_AW), .AW(AW), .DW(DW)
  ) u_port (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_valid     (reg_valid),
    .reg_write     (reg_write),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_wstrb     (reg_wstrb),
    .ctrl_flat     (ctrl_flat),
    .flag_flat     (flag_flat),
    .cap_addr_flat (cap_addr_flat),
    .cap_data_flat (cap_data_flat),
    .gie_q         (gie_q),
    .ctrl_wr       (ctrl_wr),
    .ctrl_we       (ctrl_we),
    .clr_sec       (clr_sec),
    .clr_ded       (clr_ded),
    .reg_rdata     (reg_rdata),
    .reg_rvalid    (reg_rvalid)
  );

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    unit_ctrl_t c_q;
    logic [1:0] f_q;
    logic [1:0] p;

    ecc_unit_slot #(.AW(AW), .DW(DW)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_we    (ctrl_we[u]),
      .ctrl_wr    (ctrl_wr),
      .clr_sec    (clr_sec[u]),
      .clr_ded    (clr_ded[u]),
      .ev_sec     (ev_sec[u]),
      .ev_ded     (ev_ded[u]),
      .ev_addr    (ev_addr[u*AW +: AW]),
      .ev_data    (ev_data[u*DW +: DW]),
      .ctrl_q     (c_q),
      .flags_q    (f_q),
      .cap_addr_q (cap_addr_flat[u*AW +: AW]),
      .cap_data_q (cap_data_flat[u*DW +: DW]),
      .pend       (p),
      .cap_fire   (cap_fire_vec[u])
    );

    assign ctrl_flat[3*u +: 3] = c_q;
    assign flag_flat[2*u +: 2] = f_q;
    assign pend_flat[2*u +: 2] = p;
    assign clr_flat[2*u +: 2]  = {clr_ded[u], clr_sec[u]};
  end

  ecc_irq_merge #(.N_UNITS(N_UNITS)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .gie   (gie_q),
    .pend  (pend_flat),
    .irq_q (irq)
  );

endmodule

// File: rtl/ecc_event_hub_chk.sv
module ecc_event_hub_chk #(
  parameter int unsigned N_UNITS = 4,
  parameter int unsigned AW      = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_valid,
  input logic                  reg_write,
  input logic                  reg_rvalid,
  input logic                  irq,
  input logic                  gie_q,
  input logic [3*N_UNITS-1:0]  ctrl_flat,
  input logic [2*N_UNITS-1:0]  flag_flat,
  input logic [2*N_UNITS-1:0]  clr_flat,
  input logic [2*N_UNITS-1:0]  pend_flat,
  input logic [N_UNITS*AW-1:0] cap_addr_flat
);

  logic [2*N_UNITS-1:0] en_rep;
  always_comb begin
    for (int u = 0; u < N_UNITS; u++) begin
      en_rep[2*u]   = ctrl_flat[3*u];
      en_rep[2*u+1] = ctrl_flat[3*u];
    end
  end

  AST_READ_RETURNS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rvalid == $past(reg_valid && !reg_write)); // R2

  AST_IRQ_FOLLOWS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(gie_q && (pend_flat != '0))); // R10

  AST_IRQ_GATED_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gie_q) |-> !irq); // R10

  AST_FLAG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_flat & ~$past(flag_flat)) & ~$past(en_rep)) == '0); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_flat) & ~flag_flat & ~$past(clr_flat)) == '0); // R6

  for (genvar u = 0; u < N_UNITS; u++) begin : g_cap
    AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_flat[2*u +: 2] != 2'b00 && clr_flat[2*u +: 2] == 2'b00)
        |=> $stable(cap_addr_flat[u*AW +: AW])); // R8
  end

endmodule

bind ecc_event_hub ecc_event_hub_chk #(.N_UNITS(N_UNITS), .AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_valid     (reg_valid),
  .reg_write     (reg_write),
  .reg_rvalid    (reg_rvalid),
  .irq           (irq),
  .gie_q         (gie_q),
  .ctrl_flat     (ctrl_flat),
  .flag_flat     (flag_flat),
  .clr_flat      (clr_flat),
  .pend_flat     (pend_flat),
  .cap_addr_flat (cap_addr_flat)
);

// File: tb/test_ecc_event_hub.sv
module test_ecc_event_hub;

  localparam int unsigned N  = 4;
  localparam int unsigned RA = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_valid = 1'b0;
  logic            reg_ready;
  logic            reg_write = 1'b0;
  logic [RA-1:0]   reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [3:0]      reg_wstrb = '0;
  logic [31:0]     reg_rdata;
  logic            reg_rvalid;
  logic [N-1:0]    ev_sec = '0;
  logic [N-1:0]    ev_ded = '0;
  logic [N*32-1:0] ev_addr = '0;
  logic [N*32-1:0] ev_data = '0;
  logic            irq;

  int    n_vec  = 0;
  int    n_bad  = 0;
  bit    done   = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  ecc_event_hub #(.N_UNITS(N), .REG_AW(RA), .AW(32), .DW(32)) i_ecc_event_hub (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wstrb(reg_wstrb), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .ev_sec(ev_sec), .ev_ded(ev_ded), .ev_addr(ev_addr), .ev_data(ev_data),
    .irq(irq)
  );

  function automatic logic [RA-1:0] ua(input int u, input int off);
    return RA'(32'h20 + 16 * u + off);
  endfunction

  // Monitor: compares queued expectations in the cycle read data is valid
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2: unexpected read data %h, expected no response", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [RA-1:0] a, input logic [31:0] d, input logic [3:0] s);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d; reg_wstrb = s;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0; reg_wstrb = '0;
  endtask

  task automatic rd(input logic [RA-1:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic set_ev(input int u, input logic s, input logic d,
                        input logic [31:0] a, input logic [31:0] v);
    ev_sec[u] = s; ev_ded[u] = d;
    ev_addr[u*32 +: 32] = a; ev_data[u*32 +: 32] = v;
  endtask

  task automatic pulse(input int u, input logic s, input logic d,
                       input logic [31:0] a, input logic [31:0] v);
    set_ev(u, s, d, a, v);
    @(negedge clk);
    ev_sec = '0; ev_ded = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_vec++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: irq got %b expected %b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(12'h000, 32'h0, "R1");
    rd(ua(0, 0), 32'h0, "R1");
    rd(ua(0, 4), 32'h0, "R1");
    rd(ua(2, 8), 32'h0, "R1");

    // R5 disabled unit drops events
    pulse(0, 1'b1, 1'b1, 32'hDEAD_0000, 32'h1111_1111);
    rd(ua(0, 4), 32'h0, "R5");
    rd(ua(0, 8), 32'h0, "R5");

    // R2 map and read-back
    wr(12'h000, 32'h1, 4'h1);
    wr(ua(0, 0), 32'h7, 4'h1);
    rd(ua(0, 0), 32'h7, "R2");
    rd(12'h000, 32'h1, "R2");
    rd(12'h010, 32'h0, "R2");
    rd(ua(0, 1), 32'h7, "R2");

    // R4 / R8 / R10 first error
    pulse(0, 1'b1, 1'b0, 32'hA000_0010, 32'hD000_0001);
    chk_irq(1'b0, "R10");
    @(negedge clk);
    chk_irq(1'b1, "R10");
    rd(ua(0, 4), 32'h1, "R4");
    rd(ua(0, 8), 32'hA000_0010, "R8");
    rd(ua(0, 12), 32'hD000_0001, "R8");

    // R8 frozen on second error
    pulse(0, 1'b0, 1'b1, 32'hA000_0020, 32'hD000_0002);
    rd(ua(0, 4), 32'h3, "R4");
    rd(ua(0, 8), 32'hA000_0010, "R8");
    rd(ua(0, 12), 32'hD000_0001, "R8");

    // R3 ignored writes
    wr(ua(0, 8), 32'hFFFF_FFFF, 4'hF);
    rd(ua(0, 8), 32'hA000_0010, "R3");
    wr(ua(0, 0), 32'h0, 4'h0);
    rd(ua(0, 0), 32'h7, "R3");

    // R10 per-type masks and global enable
    wr(ua(0, 0), 32'h1, 4'h1);
    @(negedge clk);
    chk_irq(1'b0, "R10");
    wr(ua(0, 0), 32'h5, 4'h1);
    @(negedge clk);
    chk_irq(1'b1, "R10");
    wr(12'h000, 32'h0, 4'h1);
    @(negedge clk);
    chk_irq(1'b0, "R10");
    wr(12'h000, 32'h1, 4'h1);
    @(negedge clk);
    chk_irq(1'b1, "R10");

    // R6 write-one-to-clear
    wr(ua(0, 4), 32'h0, 4'h1);
    rd(ua(0, 4), 32'h3, "R6");
    wr(ua(0, 4), 32'h1, 4'h1);
    rd(ua(0, 4), 32'h2, "R6");
    wr(ua(0, 4), 32'h2, 4'h1);
    rd(ua(0, 4), 32'h0, "R6");
    @(negedge clk);
    chk_irq(1'b0, "R10");

    // R9 capture re-armed after clear
    pulse(0, 1'b1, 1'b0, 32'hA000_0030, 32'hD000_0003);
    rd(ua(0, 8), 32'hA000_0030, "R9");

    // R7 event and clear on the same edge
    set_ev(0, 1'b1, 1'b0, 32'hA000_0040, 32'hD000_0004);
    wr(ua(0, 4), 32'h1, 4'h1);
    ev_sec = '0; ev_ded = '0;
    rd(ua(0, 4), 32'h1, "R7");
    rd(ua(0, 8), 32'hA000_0040, "R9");
    rd(ua(0, 12), 32'hD000_0004, "R9");

    // R4 unit independence
    wr(ua(3, 0), 32'h7, 4'h1);
    pulse(3, 1'b0, 1'b1, 32'hB000_0050, 32'hE000_0005);
    rd(ua(3, 4), 32'h2, "R4");
    rd(ua(3, 8), 32'hB000_0050, "R8");
    rd(ua(0, 4), 32'h1, "R4");
    rd(ua(1, 4), 32'h0, "R4");

    // R5 disabling keeps state, drops new events
    wr(ua(3, 0), 32'h6, 4'h1);
    pulse(3, 1'b1, 1'b0, 32'hB000_0060, 32'hE000_0006);
    rd(ua(3, 4), 32'h2, "R5");
    rd(ua(3, 8), 32'hB000_0050, "R5");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2: got %0d pending reads expected 0", exp_q.size());
    end
    done = 1'b1;
    finish_run();
  end

endmodule